// File: doc/BRIEF.md
# Translation Table Update Engine

This block carries out software commands that change or inspect a page translation table held in an external single-port RAM. It accepts four commands. A single-entry store and a single-entry load act on one table slot. A fill writes one value into a run of consecutive pages. A list store fetches 64-bit entries one by one from system memory and writes each one to the next page. Every table index comes from a bus address. The address is aligned down to the page size, the window base is subtracted from it, and the result is shifted right by the page shift. An index that falls outside the table gives a parameter error.

Multi-page commands advance one entry per step. They stop at the first entry whose index is out of range and report that error, and the entries written before the failure stay in place. Some arguments are bad before any entry is touched: a fill longer than the table, a list longer than the list limit, a list address off its 4 KiB boundary, or a zero page count. These are rejected at once, with no write. Each entry written successfully raises a one-cycle notification, so translation caches can drop any stale copy.

Top module: `xlt_update_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `rsp_valid`, `ntf_valid`, `tbl_we` and `mem_req` are all low.
- R2: The slot index is ((bus address with its low PAGE_SHIFT bits cleared) minus WIN_BASE) shifted right by PAGE_SHIFT, in ADDR_W-bit unsigned arithmetic. Two addresses in the same page therefore reach the same slot.
- R3: An index at or above DEPTH gives `rsp_status` = 1 (parameter error). An address below WIN_BASE wraps and also gives this error. Nothing is written and no notification is raised.
- R4: Opcode 0 (store) writes `cmd_arg` to the slot. `rsp_valid` rises at the second rising edge, counting the accepting edge as the first, with `rsp_status` = 0 (success).
- R5: Opcode 1 (load) returns the stored entry on `rsp_data` with status 0 at the third edge. An out-of-range load reports status 1 at the second edge.
- R6: Opcode 2 (fill) writes `cmd_arg` to `cmd_count` consecutive pages, one per edge, and on full success responds at edge `cmd_count`+1. A count of zero or a count above DEPTH is answered at the first edge with status 1, and nothing is written.
- R7: Opcode 3 (list store) is answered at the first edge with status 1, and nothing is written, when the count is zero, the count exceeds LIST_MAX (512), or `cmd_arg` has any of its low 12 bits set.
- R8: The list store reads entry i from address `cmd_arg` + 8*i and writes it to page i of the run. It has only one read outstanding: `mem_req` stays high until `mem_rvalid` returns and is never high while a table write happens.
- R9: A fill or list store that reaches an out-of-range page stops there with status 1. It responds one edge after its last good write, and the earlier writes are kept.
- R10: Each table write raises `ntf_valid` for one cycle on the same edge. The notification carries the page base address, the entry with its page-offset bits cleared, the offset mask (page size minus one) and the entry's two low permission bits.
- R11: `busy` is high from the accepting edge until the edge that raises `rsp_valid`, and it is low whenever `rsp_valid` is high. A command presented while `busy` is high is ignored.
- R12: `rsp_valid` is high for exactly one cycle per accepted command. The status encoding is 0 for success and 1 for a parameter error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_op | input | 2 | 0 store, 1 load, 2 fill, 3 list store |
| cmd_addr | input | ADDR_W | Bus address of the first page |
| cmd_arg | input | DATA_W | Entry value, or the list address for opcode 3 |
| cmd_count | input | CNT_W | Page count for fill and list store |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 1 | 0 success, 1 parameter error |
| rsp_data | output | DATA_W | Entry returned by a load |
| tbl_we | output | 1 | Table write enable |
| tbl_addr | output | IDX_W | Table slot address |
| tbl_wdata | output | DATA_W | Table write data |
| tbl_rdata | input | DATA_W | Table read data, one cycle after the address |
| mem_req | output | 1 | List read request, held until answered |
| mem_addr | output | ADDR_W | List read address |
| mem_rvalid | input | 1 | List read data valid |
| mem_rdata | input | DATA_W | List read data |
| ntf_valid | output | 1 | Notification strobe |
| ntf_iova | output | ADDR_W | Page base bus address of the written slot |
| ntf_xlat | output | DATA_W | Translated base (entry with offset bits cleared) |
| ntf_mask | output | DATA_W | Page-offset mask |
| ntf_perm | output | 2 | Permission bits of the entry |

## Verification
Each command is driven on a falling edge, and the bench then counts rising edges until `rsp_valid` is seen. Rejections found at once must answer at edge 1, a store or a failing load at edge 2, a good load at edge 3, and a fill of n good pages at edge n+1; a run that stops after k good writes must answer at edge k+2. List-store latency depends on the random memory delay, so only the order and content of its notifications are checked. Every notification is compared, on the edge where it appears, with the page and entry the bench model expects next.

// File: rtl/xlt_pkg.sv
// Shared types for the translation table update engine.
// Assumes a 2-bit opcode field and a 1-bit status code.
package xlt_pkg;
    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } xlt_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STEP,
        S_FETCH,
        S_GET,
        S_GETD
    } xlt_state_e;

    localparam logic ST_OK    = 1'b0;
    localparam logic ST_PARAM = 1'b1;
endpackage

// File: rtl/xlt_index.sv
// Maps a page-aligned bus address to a table slot and flags whether the
// slot exists. Assumes the address is already aligned; the subtraction
// wraps, so addresses below the window base come out as out of range.
module xlt_index #(
    parameter int                 ADDR_W     = 32,
    parameter int                 PAGE_SHIFT = 12,
    parameter int                 DEPTH      = 64,
    parameter logic [ADDR_W-1:0]  WIN_BASE   = '0,
    parameter int                 IDX_W      = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] page;

    // Offset from the window base; a zero base needs no subtractor.
    generate
        if (WIN_BASE == '0) begin : g_nobase
            assign rel = addr;
        end else begin : g_base
            assign rel = addr - WIN_BASE;
        end
    endgenerate

    // Page number, range flag and truncated slot address.
    always_comb begin
        page = rel >> PAGE_SHIFT;
        hit  = page < DEPTH_A;
        idx  = page[IDX_W-1:0];
    end
endmodule

// File: rtl/xlt_notify.sv
// Registers a notification for each table write: page base, translated base,
// offset mask and permission bits. Assumes one write at most per cycle.
module xlt_notify #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] page_addr,
    input  logic [DATA_W-1:0] entry,
    output logic              ntf_valid,
    output logic [ADDR_W-1:0] ntf_iova,
    output logic [DATA_W-1:0] ntf_xlat,
    output logic [DATA_W-1:0] ntf_mask,
    output logic [1:0]        ntf_perm
);
    localparam logic [DATA_W-1:0] OFS_MASK = (DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1);

    // Capture the fields of the entry being written this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_valid <= 1'b0;
            ntf_iova  <= '0;
            ntf_xlat  <= '0;
            ntf_perm  <= '0;
        end else begin
            ntf_valid <= fire;
            if (fire) begin
                ntf_iova <= page_addr;
                ntf_xlat <= entry & ~OFS_MASK;
                ntf_perm <= entry[1:0];
            end
        end
    end

    assign ntf_mask = OFS_MASK;
endmodule

// File: rtl/xlt_update_engine.sv
// Command engine that stores, loads, fills and list-stores entries of a
// translation table kept in an external RAM with one cycle of read latency.
// Multi-page commands run one entry per step and stop at the first slot out
// of range. List entries are fetched with one read outstanding at a time.
module xlt_update_engine
    import xlt_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 64,
    parameter int                PAGE_SHIFT = 12,
    parameter int                DEPTH      = 64,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0010_0000,
    parameter int                CNT_W      = 16,
    parameter int                LIST_MAX   = 512,
    parameter int                LIST_ALIGN = 12,
    localparam int               IDX_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_arg,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_status,
    output logic [DATA_W-1:0] rsp_data,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_addr,
    output logic [DATA_W-1:0] tbl_wdata,
    input  logic [DATA_W-1:0] tbl_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ntf_valid,
    output logic [ADDR_W-1:0] ntf_iova,
    output logic [DATA_W-1:0] ntf_xlat,
    output logic [DATA_W-1:0] ntf_mask,
    output logic [1:0]        ntf_perm
);
    localparam logic [ADDR_W-1:0] PAGE_SZ   = ADDR_W'(1) << PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] PAGE_MSK  = ~(PAGE_SZ - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] SLOT_SZ   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] PERM_CLR  = ~ADDR_W'(3);
    localparam logic [CNT_W-1:0]  DEPTH_C   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  LISTMAX_C = CNT_W'(LIST_MAX);

    xlt_state_e        state;
    xlt_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] val_q;
    logic [ADDR_W-1:0] list_q;
    logic [CNT_W-1:0]  left_q;
    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic              cnt_zero;
    logic              fill_bad;
    logic              list_bad;

    xlt_index #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .DEPTH     (DEPTH),
        .WIN_BASE  (WIN_BASE),
        .IDX_W     (IDX_W)
    ) i_index (
        .addr(addr_q),
        .idx (idx),
        .hit (hit)
    );

    // Argument checks that reject a command before any entry is touched.
    always_comb begin
        cnt_zero = (cmd_count == '0);
        fill_bad = cnt_zero || (cmd_count > DEPTH_C);
        list_bad = cnt_zero || (cmd_count > LISTMAX_C) || (|cmd_arg[LIST_ALIGN-1:0]);
    end

    // Command sequencer: accept, step through pages, fetch list entries, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= OP_PUT;
            addr_q     <= '0;
            val_q      <= '0;
            list_q     <= '0;
            left_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q   <= xlt_op_e'(cmd_op);
                        addr_q <= cmd_addr & PAGE_MSK;
                        val_q  <= cmd_arg;
                        list_q <= cmd_arg[ADDR_W-1:0] & PERM_CLR;
                        left_q <= cmd_count;
                        unique case (xlt_op_e'(cmd_op))
                            OP_PUT: begin
                                left_q <= CNT_W'(1);
                                state  <= S_STEP;
                            end
                            OP_GET: state <= S_GET;
                            OP_FILL: begin
                                if (fill_bad) begin
                                    rsp_valid  <= 1'b1;
                                    rsp_status <= ST_PARAM;
                                end else begin
                                    state <= S_STEP;
                                end
                            end
                            OP_LIST: begin
                                if (list_bad) begin
                                    rsp_valid  <= 1'b1;
                                    rsp_status <= ST_PARAM;
                                end else begin
                                    state <= S_FETCH;
                                end
                            end
                            default: state <= S_IDLE;
                        endcase
                    end
                end
                S_STEP: begin
                    if (!hit) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_PARAM;
                        state      <= S_IDLE;
                    end else begin
                        addr_q <= addr_q + PAGE_SZ;
                        left_q <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            rsp_valid  <= 1'b1;
                            rsp_status <= ST_OK;
                            state      <= S_IDLE;
                        end else if (op_q == OP_LIST) begin
                            state <= S_FETCH;
                        end
                    end
                end
                S_FETCH: begin
                    if (mem_rvalid) begin
                        val_q  <= mem_rdata;
                        list_q <= list_q + SLOT_SZ;
                        state  <= S_STEP;
                    end
                end
                S_GET: begin
                    if (!hit) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_PARAM;
                        state      <= S_IDLE;
                    end else begin
                        state <= S_GETD;
                    end
                end
                S_GETD: begin
                    rsp_data   <= tbl_rdata;
                    rsp_valid  <= 1'b1;
                    rsp_status <= ST_OK;
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Table and memory port drive, decoded from the current step.
    always_comb begin
        busy      = (state != S_IDLE);
        tbl_we    = (state == S_STEP) && hit;
        tbl_addr  = idx;
        tbl_wdata = val_q;
        mem_req   = (state == S_FETCH);
        mem_addr  = list_q;
    end

    xlt_notify #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) i_notify (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (tbl_we),
        .page_addr(addr_q),
        .entry    (val_q),
        .ntf_valid(ntf_valid),
        .ntf_iova (ntf_iova),
        .ntf_xlat (ntf_xlat),
        .ntf_mask (ntf_mask),
        .ntf_perm (ntf_perm)
    );
endmodule

// File: rtl/xlt_update_engine_chk.sv
// Protocol checker for the update engine, bound to every instance of it.
// Assumes the synchronous active-low reset of the engine.
module xlt_update_engine_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rsp_valid,
    input logic              tbl_we,
    input logic [DATA_W-1:0] tbl_wdata,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic              ntf_valid,
    input logic [1:0]        ntf_perm
);
    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    // R11
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> busy);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> mem_req);

    // R8
    fetch_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tbl_we));

    // R10
    ntf_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> ntf_valid);

    // R10
    ntf_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> (ntf_perm == $past(tbl_wdata[1:0])));
endmodule

bind xlt_update_engine xlt_update_engine_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .tbl_we    (tbl_we),
    .tbl_wdata (tbl_wdata),
    .mem_req   (mem_req),
    .mem_rvalid(mem_rvalid),
    .ntf_valid (ntf_valid),
    .ntf_perm  (ntf_perm)
);

// File: tb/test_xlt_update_engine.sv
module test_xlt_update_engine;
    localparam int          AW    = 32;
    localparam int          DW    = 64;
    localparam int          DEPTH = 64;
    localparam logic [31:0] BASE  = 32'h0010_0000;
    localparam logic [31:0] PAGE  = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_arg = '0;
    logic [15:0]   cmd_count = '0;
    logic          busy, rsp_valid, rsp_status;
    logic [DW-1:0] rsp_data;
    logic          tbl_we;
    logic [5:0]    tbl_addr;
    logic [DW-1:0] tbl_wdata;
    logic [DW-1:0] tbl_rdata = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          ntf_valid;
    logic [AW-1:0] ntf_iova;
    logic [DW-1:0] ntf_xlat, ntf_mask;
    logic [1:0]    ntf_perm;

    int errors = 0;
    int checks = 0;

    logic [DW-1:0] ram [DEPTH];
    logic [DW-1:0] exp_tbl [DEPTH];
    logic [DW-1:0] list_mem [1024];
    int            dly = 0;

    always #5 clk = ~clk;

    xlt_update_engine i_xlt_update_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_arg(cmd_arg), .cmd_count(cmd_count),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_data(rsp_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat),
        .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
    );

    // Table RAM model with one cycle of read latency.
    always @(posedge clk) begin
        if (tbl_we) ram[tbl_addr] <= tbl_wdata;
        tbl_rdata <= ram[tbl_addr];
    end

    // List memory model: answers a held request after 1 to 3 cycles.
    always @(posedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
        end else if (mem_req) begin
            if (dly == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= list_mem[(mem_addr >> 3) & 32'd1023];
                dly        <= int'($urandom % 3);
            end else begin
                dly <= dly - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_rng(input logic [31:0] a);
        logic [31:0] d;
        d = a - BASE;
        return (d >> 12) < DEPTH;
    endfunction

    function automatic int idx_of(input logic [31:0] a);
        logic [31:0] d;
        d = a - BASE;
        return int'((d >> 12) % DEPTH);
    endfunction

    // Issue one command and check latency, status, data and notifications.
    task automatic do_cmd(input logic [1:0] op, input logic [31:0] addr,
                          input logic [63:0] arg, input int cnt, input bit poke,
                          input string req);
        logic [31:0] al;
        bit          imm;
        int          n, okn, lat, seen, exp_lat;
        bit          exp_err, busy_bad, done;
        logic [63:0] ent;
        al  = addr & ~(PAGE - 1);
        imm = (op == 2'd2 && (cnt == 0 || cnt > DEPTH)) ||
              (op == 2'd3 && (cnt == 0 || cnt > 512 || arg[11:0] != 12'd0));
        n   = (op == 2'd0) ? 1 : (op == 2'd1 ? 0 : cnt);
        okn = 0;
        if (!imm) begin
            for (int k = 0; k < n; k++) begin
                if (!in_rng(al + PAGE * k)) break;
                okn++;
            end
        end
        if (imm) begin
            exp_err = 1'b1; exp_lat = 1;
        end else if (op == 2'd1) begin
            exp_err = !in_rng(al); exp_lat = exp_err ? 2 : 3;
        end else begin
            exp_err = (okn < n); exp_lat = exp_err ? okn + 2 : okn + 1;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_arg = arg;
        cmd_count = 16'(cnt);
        @(posedge clk);
        lat = 0; seen = 0; busy_bad = 1'b0; done = 1'b0;
        for (int t = 0; t < 4000 && !done; t++) begin
            @(negedge clk);
            lat++;
            cmd_valid = 1'b0;
            if (poke && t == 0) begin
                cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = BASE + PAGE * 40;
                cmd_arg = 64'hDEAD_BEEF_0000_0003;
            end
            if (ntf_valid) begin
                ent = (op == 2'd3) ? list_mem[((arg >> 3) + 64'(seen)) & 64'd1023] : arg;
                check(ntf_iova == al + PAGE * seen, "R10 iova", 64'(ntf_iova),
                      64'(al + PAGE * seen));
                check(ntf_xlat == (ent & ~64'hFFF) && ntf_perm == ent[1:0] &&
                      ntf_mask == 64'hFFF, "R10 fields", ntf_xlat, ent & ~64'hFFF);
                if (op != 2'd1 && seen < okn) exp_tbl[idx_of(al + PAGE * seen)] = ent;
                seen++;
            end
            if (rsp_valid) done = 1'b1;
            else if (!busy) busy_bad = 1'b1;
        end
        cmd_valid = 1'b0;
        if (!done) check(1'b0, {req, " response timeout"}, 64'(lat), 64'(exp_lat));
        check(rsp_status == exp_err, {req, " status"}, 64'(rsp_status), 64'(exp_err));
        if (op != 2'd3)
            check(lat == exp_lat, {req, " latency"}, 64'(lat), 64'(exp_lat));
        check(seen == okn, {req, " writes"}, 64'(seen), 64'(okn));
        check(!busy_bad && !busy, "R11 busy window", 64'(busy), 64'(0));
        if (op == 2'd1 && !exp_err)
            check(rsp_data == exp_tbl[idx_of(al)], {req, " data"}, rsp_data,
                  exp_tbl[idx_of(al)]);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; exp_tbl[i] = '0; end
        for (int i = 0; i < 1024; i++) list_mem[i] = {$urandom, $urandom};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!busy && !rsp_valid && !ntf_valid && !tbl_we && !mem_req, "R1 reset",
              {59'd0, busy, rsp_valid, ntf_valid, tbl_we, mem_req}, 64'd0);
        rst_n = 1'b1;
        // R2 R4 store with offset bits, load from another offset in the page
        do_cmd(2'd0, BASE + PAGE * 3 + 32'h123, 64'h1234_5678_9ABC_D002, 0, 0, "R4 store");
        do_cmd(2'd1, BASE + PAGE * 3 + 32'h7, 64'd0, 0, 0, "R2 R5 load");
        // R3 out of range: below base, at depth; R5 load beyond
        do_cmd(2'd0, BASE - 32'h10, 64'h55, 0, 0, "R3 below base");
        do_cmd(2'd0, BASE + PAGE * DEPTH, 64'h56, 0, 0, "R3 at depth");
        do_cmd(2'd1, BASE + PAGE * DEPTH, 64'd0, 0, 0, "R5 load range");
        // R6 fill and its rejections
        do_cmd(2'd2, BASE + PAGE * 10, 64'hAAAA_0000_0000_5001, 5, 0, "R6 fill");
        do_cmd(2'd2, BASE, 64'h1, 0, 0, "R6 fill zero");
        do_cmd(2'd2, BASE, 64'h1, DEPTH + 1, 0, "R6 fill long");
        // R9 fill runs off the end
        do_cmd(2'd2, BASE + PAGE * 62, 64'hBBBB_0000_0000_7003, 5, 0, "R9 fill stop");
        // R8 list store; R7 rejections; R9 list runs off the end
        do_cmd(2'd3, BASE + PAGE * 20, 64'h2000, 6, 0, "R8 list");
        do_cmd(2'd3, BASE, 64'h2008, 2, 0, "R7 misaligned");
        do_cmd(2'd3, BASE, 64'h2000, 513, 0, "R7 too long");
        do_cmd(2'd3, BASE, 64'h2000, 0, 0, "R7 zero");
        do_cmd(2'd3, BASE + PAGE * 61, 64'h1000, 6, 0, "R9 list stop");
        // R11 a store offered while busy must not land in slot 40
        do_cmd(2'd2, BASE + PAGE * 44, 64'h77, 4, 1, "R11 fill");
        do_cmd(2'd1, BASE + PAGE * 40, 64'd0, 0, 0, "R11 ignored load");
        // Random mix (R2 R3 R4 R5 R6 R8 R9 R12)
        for (int r = 0; r < 80; r++) begin
            logic [1:0]  op;
            logic [31:0] a;
            int          c;
            op = 2'($urandom % 4);
            a  = BASE + PAGE * ($urandom % 72) + ($urandom % 4096);
            if ($urandom % 10 == 0) a = BASE - PAGE;
            c  = 1 + int'($urandom % 8);
            if ($urandom % 12 == 0) c = 0;
            if (op == 2'd3)
                do_cmd(op, a, 64'(32'h1000 * (1 + $urandom % 3)), c, 0, "R12 random list");
            else
                do_cmd(op, a, {$urandom, $urandom}, c, 0, "R12 random");
        end
        // R5 final scan of every slot
        for (int i = 0; i < DEPTH; i++)
            do_cmd(2'd1, BASE + PAGE * i, 64'd0, 0, 0, "R5 scan");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule